// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block sets the framing of a time-division multiplexed audio link. It counts bit-clock ticks into frames of a programmable length and tells the serializers where each bit sits: which slot, and which bit inside that slot. It also strobes the first bit of every frame. As master it drives the frame sync line itself. The sync can be a one-bit pulse, placed on the first bit of the frame or on the bit just before it. It can also be a pulse that spans a whole slot.

As slave it leaves the sync output low and follows a sync line from outside. The counters lock to the first rising edge seen on that line. After that they run freely and realign at every later edge. An edge that comes at the wrong count sets a sticky error flag. A configuration whose frame cannot hold its slots is flagged combinationally, and the block stays idle. Clock generation and register access belong to the surrounding logic.

Top module: `tdm_sync_gen`

## Requirements
- R1: The frame period is frameDiv+1 bit ticks. frameStart is high for one clock cycle, in the cycle after the tick that makes the frame's bit 0 current. It is never high at any other time.
- R2: When master with longSync=0 and earlySync=0, frameSync is high only while bit 0 of the frame is current.
- R3: When master with longSync=0 and earlySync=1, frameSync is high only while bit frameDiv (the last bit of a frame) is current. The first frame after start has no preceding pulse.
- R4: When master with longSync=1, frameSync is high while the bit position within the frame is below the slot length. earlySync has no effect in this mode.
- R5: cfgIllegal is 1 when the slot length is 0, or slotCount is 0, or frameDiv+1 is less than slot length times slotCount. While cfgIllegal is 1 the block does not start: frameSync, frameStart, bitIdx and slotIdx stay 0.
- R6: With longSync=1, cfgIllegal is also 1 when frameDiv+1 is not strictly greater than the slot length.
- R7: While globalEn=0 all outputs except cfgIllegal are held at 0, and the error flag is cleared. Counting restarts from bit 0 when the block is enabled again.
- R8: When slaveSel=1, frameSync stays 0 and extSync is sampled on ticks. Counting begins at the first sampled rising edge of extSync. With longSync=1 or earlySync=0, that tick makes bit 0 current. With longSync=0 and earlySync=1, the following tick makes bit 0 current.
- R9: In slave mode, every later rising edge of extSync forces the frame alignment again. syncErr is set, and stays set until globalEn=0, when such an edge arrives at any count other than the expected frame boundary.
- R10: bitIdx and slotIdx are 0 at every frame start. bitIdx counts 0 up to slot length minus 1 and wraps. slotIdx advances on each wrap and saturates at slotCount during the padding bits at the end of the frame.
- R11: The slot length used for framing and for the legality checks is the larger of txSlotLen and rxSlotLen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe per bit clock |
| globalEn | input | 1 | Global run enable |
| slaveSel | input | 1 | 0 master, 1 slave |
| longSync | input | 1 | 0 one-bit sync, 1 slot-wide sync |
| earlySync | input | 1 | One-bit sync placement: 0 on bit 0, 1 on the bit before the frame |
| frameDiv | input | DIV_W | Frame period minus one, in bit ticks |
| txSlotLen | input | LEN_W | Transmit slot length in bits |
| rxSlotLen | input | LEN_W | Receive slot length in bits |
| slotCount | input | CNT_W | Slots per frame |
| extSync | input | 1 | External frame sync in slave mode |
| frameSync | output | 1 | Frame sync driven in master mode |
| frameStart | output | 1 | One-cycle strobe at each frame's bit 0 |
| slotIdx | output | CNT_W | Current slot, saturating at slotCount |
| bitIdx | output | LEN_W | Current bit within the slot |
| cfgIllegal | output | 1 | Configuration cannot be framed |
| syncErr | output | 1 | Sticky misplaced-sync flag |

## Verification
The hardest case to reach is a slave-mode sync edge that lands at the wrong count while the counters are already locked. Getting there takes a first edge to lock, a full free-running frame, and then an external frame whose length differs from frameDiv+1. The bench drives extSync from its own external frame counter, which has its own period and pulse width. It then runs this counter at the matching period in late, early and long modes, and afterwards three ticks too long. The early-mode slave case is also covered: there, realignment takes effect one tick after the edge.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;
  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic clear;        // not running: zero all framing state
    logic tick;         // running and a bit tick is present
    logic restartNow;   // this tick becomes bit 0
    logic restartNext;  // the following tick becomes bit 0
    logic master;       // drive the sync line and free-run from start
  } syncStrobes_t;
endpackage

// File: rtl/tdm_sync_ctrl.sv
module tdm_sync_ctrl
  import tdm_sync_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int LEN_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             globalEn,
  input  logic             slaveSel,
  input  logic             longSync,
  input  logic             earlySync,
  input  logic [DIV_W-1:0] frameDiv,
  input  logic [LEN_W-1:0] txSlotLen,
  input  logic [LEN_W-1:0] rxSlotLen,
  input  logic [CNT_W-1:0] slotCount,
  input  logic             extSync,
  input  logic             active,
  input  logic             wrapNow,
  input  logic             lastNext,
  output syncStrobes_t     st,
  output logic [LEN_W-1:0] maxLen,
  output logic             cfgIllegal,
  output logic             syncErr
);
  localparam int PW = LEN_W + CNT_W;
  localparam int CW = ((DIV_W + 1) > PW) ? (DIV_W + 1) : PW;

  logic [CW-1:0] periodW;
  logic [CW-1:0] needW;
  logic [CW-1:0] lenW;
  logic          runNow;
  logic          prevSync;
  logic          syncEdge;
  logic          edgeOnTime;

  // R11: the wider of the two slot lengths sets the framing
  assign maxLen  = (txSlotLen >= rxSlotLen) ? txSlotLen : rxSlotLen;
  assign periodW = CW'(frameDiv) + CW'(1);
  assign needW   = CW'(maxLen) * CW'(slotCount);
  assign lenW    = CW'(maxLen);

  // R5, R6: legality of the frame geometry
  assign cfgIllegal = (maxLen == '0) || (slotCount == '0) || (periodW < needW) ||
                      (longSync && (periodW <= lenW));

  assign runNow   = globalEn && !cfgIllegal;
  assign syncEdge = runNow && slaveSel && bitTick && extSync && !prevSync;

  always_comb begin
    st.clear       = !runNow;
    st.tick        = runNow && bitTick;
    st.master      = !slaveSel;
    st.restartNow  = syncEdge && (longSync || !earlySync);
    st.restartNext = syncEdge && !longSync && earlySync;
  end

  // Expected position for a valid edge depends on the sync placement
  assign edgeOnTime = (longSync || !earlySync) ? wrapNow : lastNext;

  always_ff @(posedge clk) begin
    if (!rstN || !runNow || !slaveSel) prevSync <= 1'b0;
    else if (bitTick)                  prevSync <= extSync;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !globalEn)                     syncErr <= 1'b0;
    else if (syncEdge && active && !edgeOnTime) syncErr <= 1'b1;
  end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (globalEn && $past(syncErr)) |-> syncErr);

endmodule

// File: rtl/tdm_sync_dp.sv
module tdm_sync_dp
  import tdm_sync_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int LEN_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  syncStrobes_t     st,
  input  logic [DIV_W-1:0] frameDiv,
  input  logic [LEN_W-1:0] maxLen,
  input  logic [CNT_W-1:0] slotCount,
  input  logic             longSync,
  input  logic             earlySync,
  output logic             frameSync,
  output logic             frameStart,
  output logic [CNT_W-1:0] slotIdx,
  output logic [LEN_W-1:0] bitIdx,
  output logic             active,
  output logic             wrapNow,
  output logic             lastNext
);
  localparam int MW = (DIV_W > LEN_W) ? DIV_W : LEN_W;

  logic [DIV_W-1:0] pos;
  logic             pending;
  logic             forceZero;
  logic             go;
  logic [DIV_W-1:0] nextPos;
  logic [LEN_W-1:0] nextBit;
  logic [CNT_W-1:0] nextSlot;
  logic             syncNext;

  assign wrapNow  = active && (pos == frameDiv);
  assign lastNext = active && ((DIV_W+1)'(pos) + (DIV_W+1)'(1) == (DIV_W+1)'(frameDiv));

  always_comb begin
    forceZero = st.restartNow || pending;
    go        = st.tick && (forceZero || active || st.master);
    if (forceZero || !active || wrapNow) nextPos = '0;
    else                                 nextPos = pos + DIV_W'(1);

    // R10: indices follow the position, slot saturates in padding
    if (nextPos == '0) begin
      nextBit  = '0;
      nextSlot = '0;
    end else if (bitIdx == maxLen - LEN_W'(1)) begin
      nextBit  = '0;
      nextSlot = (slotIdx < slotCount) ? slotIdx + CNT_W'(1) : slotIdx;
    end else begin
      nextBit  = bitIdx + LEN_W'(1);
      nextSlot = slotIdx;
    end

    if (!st.master)    syncNext = 1'b0;
    else if (longSync) syncNext = MW'(nextPos) < MW'(maxLen);
    else if (earlySync) syncNext = (nextPos == frameDiv);
    else               syncNext = (nextPos == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.clear) begin
      active     <= 1'b0;
      pos        <= '0;
      pending    <= 1'b0;
      bitIdx     <= '0;
      slotIdx    <= '0;
      frameSync  <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= 1'b0;
      if (st.tick) pending <= st.restartNext;
      if (go) begin
        active     <= 1'b1;
        pos        <= nextPos;
        bitIdx     <= nextBit;
        slotIdx    <= nextSlot;
        frameSync  <= syncNext;
        frameStart <= (nextPos == '0);
      end
    end
  end

  assert_start_on_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> $past(st.tick));
  assert_start_zero_idx_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (bitIdx == '0 && slotIdx == '0));
  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!st.master && st.tick) |-> !frameSync);

endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen
  import tdm_sync_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int LEN_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             globalEn,
  input  logic             slaveSel,
  input  logic             longSync,
  input  logic             earlySync,
  input  logic [DIV_W-1:0] frameDiv,
  input  logic [LEN_W-1:0] txSlotLen,
  input  logic [LEN_W-1:0] rxSlotLen,
  input  logic [CNT_W-1:0] slotCount,
  input  logic             extSync,
  output logic             frameSync,
  output logic             frameStart,
  output logic [CNT_W-1:0] slotIdx,
  output logic [LEN_W-1:0] bitIdx,
  output logic             cfgIllegal,
  output logic             syncErr
);
  syncStrobes_t     st;
  logic [LEN_W-1:0] maxLen;
  logic             active;
  logic             wrapNow;
  logic             lastNext;

  tdm_sync_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .globalEn(globalEn),
    .slaveSel(slaveSel), .longSync(longSync), .earlySync(earlySync),
    .frameDiv(frameDiv), .txSlotLen(txSlotLen), .rxSlotLen(rxSlotLen),
    .slotCount(slotCount), .extSync(extSync), .active(active),
    .wrapNow(wrapNow), .lastNext(lastNext), .st(st), .maxLen(maxLen),
    .cfgIllegal(cfgIllegal), .syncErr(syncErr)
  );

  tdm_sync_dp #(.DIV_W(DIV_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .frameDiv(frameDiv), .maxLen(maxLen),
    .slotCount(slotCount), .longSync(longSync), .earlySync(earlySync),
    .frameSync(frameSync), .frameStart(frameStart), .slotIdx(slotIdx),
    .bitIdx(bitIdx), .active(active), .wrapNow(wrapNow), .lastNext(lastNext)
  );

  assert_illegal_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgIllegal |=> (!frameStart && !frameSync));
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> (!frameStart && !frameSync && bitIdx == '0 && slotIdx == '0 && !syncErr));

endmodule

// File: tb/tdm_sync_gen_tb.sv
`timescale 1ns/1ps
module tdm_sync_gen_tb_top;
  localparam int DIV_W = 10;
  localparam int LEN_W = 6;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, globalEn = 1'b0, slaveSel = 1'b0;
  logic longSync = 1'b0, earlySync = 1'b0, extSync = 1'b0;
  logic [DIV_W-1:0] frameDiv = '0;
  logic [LEN_W-1:0] txSlotLen = '0, rxSlotLen = '0;
  logic [CNT_W-1:0] slotCount = '0;
  logic frameSync, frameStart, cfgIllegal, syncErr;
  logic [CNT_W-1:0] slotIdx;
  logic [LEN_W-1:0] bitIdx;

  always #2 clk = ~clk;

  tdm_sync_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .globalEn(globalEn),
    .slaveSel(slaveSel), .longSync(longSync), .earlySync(earlySync),
    .frameDiv(frameDiv), .txSlotLen(txSlotLen), .rxSlotLen(rxSlotLen),
    .slotCount(slotCount), .extSync(extSync), .frameSync(frameSync),
    .frameStart(frameStart), .slotIdx(slotIdx), .bitIdx(bitIdx),
    .cfgIllegal(cfgIllegal), .syncErr(syncErr)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int mPos = 0, mActive = 0, mPend = 0, mPrev = 0, mFs = 0, mSync = 0, mErr = 0, mIll = 0;
  int mLen = 0;
  // stimulus state
  int cycN = 0, tickDiv = 2, extOn = 0, extPos = 0, extPer = 14, extHigh = 1;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cycN);
    end
  endtask

  function automatic int legalityOf();
    int ml, per;
    ml  = (txSlotLen >= rxSlotLen) ? txSlotLen : rxSlotLen;
    per = frameDiv + 1;
    return (ml == 0 || slotCount == 0 || per < ml * slotCount || (longSync && per <= ml)) ? 1 : 0;
  endfunction

  task automatic modelStep();
    int div, np, go, edgeSeen;
    div  = frameDiv;
    mLen = (txSlotLen >= rxSlotLen) ? txSlotLen : rxSlotLen;
    mIll = legalityOf();
    if (!rstN || !globalEn || mIll) begin
      mActive = 0; mPos = 0; mPend = 0; mPrev = 0; mFs = 0; mSync = 0;
      if (!rstN || !globalEn) mErr = 0;
    end else begin
      mFs = 0;
      if (bitTick) begin
        go = 0; np = 0;
        if (!slaveSel) begin
          mPrev = 0;
          go = 1;
          np = mActive ? ((mPos == div) ? 0 : mPos + 1) : 0;
        end else begin
          edgeSeen = (extSync && !mPrev) ? 1 : 0;
          mPrev = extSync;
          if (edgeSeen && mActive) begin
            if (longSync || !earlySync) begin
              if (mPos != div) mErr = 1;
            end else if (mPos + 1 != div) mErr = 1;
          end
          if (mPend) begin go = 1; np = 0; end
          else if (edgeSeen && (longSync || !earlySync)) begin go = 1; np = 0; end
          else if (mActive) begin go = 1; np = (mPos == div) ? 0 : mPos + 1; end
          mPend = (edgeSeen && !longSync && earlySync) ? 1 : 0;
        end
        if (go) begin
          mActive = 1; mPos = np; mFs = (np == 0);
          if (!slaveSel)
            mSync = longSync ? (np < mLen) : earlySync ? (np == div) : (np == 0);
          else
            mSync = 0;
        end
      end
    end
  endtask

  function automatic string syncTag();
    if (slaveSel) return "R8";
    if (longSync) return "R4";
    if (earlySync) return "R3";
    return "R2";
  endfunction

  task automatic compareAll();
    int expBit, expSlot;
    expBit  = (mActive && mLen > 0) ? (mPos % mLen) : 0;
    expSlot = (mActive && mLen > 0) ? ((mPos / mLen < slotCount) ? mPos / mLen : slotCount) : 0;
    check(syncTag(), "frameSync", frameSync, mSync);
    check("R1", "frameStart", frameStart, mFs);
    check("R10", "bitIdx", bitIdx, expBit);
    check("R10", "slotIdx", slotIdx, expSlot);
    check("R5", "cfgIllegal", cfgIllegal, legalityOf());
    check("R9", "syncErr", syncErr, mErr);
  endtask

  task automatic cycle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      if (bitTick) extPos = (extPos + 1) % extPer;
      @(negedge clk);
      compareAll();
      cycN++;
      bitTick = (tickDiv == 1) || (cycN % tickDiv == 0);
      extSync = extOn && (extPos < extHigh);
    end
  endtask

  task automatic pauseAndSet(int div, int tx, int rx, int cnt, bit slv, bit lng, bit early);
    globalEn = 1'b0;
    cycle(2);
    check("R7", "frameStart while disabled", frameStart, 0);
    check("R7", "syncErr while disabled", syncErr, 0);
    frameDiv = DIV_W'(div); txSlotLen = LEN_W'(tx); rxSlotLen = LEN_W'(rx);
    slotCount = CNT_W'(cnt); slaveSel = slv; longSync = lng; earlySync = early;
    cycle(1);
    globalEn = 1'b1;
  endtask

  initial begin
    // reset state
    cycle(4);
    check("R7", "reset frameSync", frameSync, 0);
    check("R7", "reset slotIdx", slotIdx, 0);
    rstN = 1'b1;

    // R2: master, one-bit late sync, padding of two bits
    pauseAndSet(13, 4, 4, 3, 0, 0, 0);
    cycle(120);
    // R3: early placement
    pauseAndSet(13, 4, 4, 3, 0, 0, 1);
    cycle(120);
    // R4 and R11: long sync, earlySync set but ignored, wider rx slot
    pauseAndSet(13, 4, 6, 2, 0, 1, 1);
    cycle(120);
    // R5: frame too short for its slots
    pauseAndSet(10, 4, 4, 3, 0, 0, 0);
    cycle(30);
    check("R5", "illegal frame stays idle", frameStart | frameSync, 0);
    check("R5", "cfgIllegal for short frame", cfgIllegal, 1);
    // R6: long sync needs period above slot length
    globalEn = 1'b0;
    frameDiv = 7; txSlotLen = 8; rxSlotLen = 8; slotCount = 1; longSync = 1'b1;
    cycle(1);
    check("R6", "cfgIllegal long sync period equal slot", cfgIllegal, 1);
    longSync = 1'b0;
    cycle(1);
    check("R6", "cfgIllegal short sync same geometry", cfgIllegal, 0);
    // R11: rx longer makes 2 slots overflow an 11-bit frame
    frameDiv = 10; txSlotLen = 4; rxSlotLen = 6; slotCount = 2;
    cycle(1);
    check("R11", "cfgIllegal with wider rx slot", cfgIllegal, 1);
    rxSlotLen = 4;
    cycle(1);
    check("R11", "cfgIllegal with equal slots", cfgIllegal, 0);
    // R1: tick every cycle, small frame
    tickDiv = 1;
    pauseAndSet(5, 2, 2, 3, 0, 0, 0);
    cycle(40);
    tickDiv = 2;
    // R8: slave, late placement, external frame matches
    extPer = 14; extHigh = 1; extPos = 5; extOn = 1;
    pauseAndSet(13, 4, 4, 3, 1, 0, 0);
    cycle(150);
    check("R9", "no error on matching frames", syncErr, 0);
    // R8: slave early placement
    extPos = 3;
    pauseAndSet(13, 4, 4, 3, 1, 0, 1);
    cycle(150);
    check("R9", "no error early matching", syncErr, 0);
    // R8: slave long sync
    extHigh = 4; extPos = 9;
    pauseAndSet(13, 4, 4, 3, 1, 1, 0);
    cycle(150);
    // R9: external frame three ticks too long
    extPer = 17; extHigh = 1; extPos = 2;
    pauseAndSet(13, 4, 4, 3, 1, 0, 0);
    cycle(150);
    check("R9", "error on misplaced sync", syncErr, 1);
    globalEn = 1'b0;
    cycle(2);
    check("R7", "disable clears error", syncErr, 0);
    extOn = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule